// File: doc/BRIEF.md
# BISYNC Receive Block Framer

This block sits behind a byte-synchronous deserializer and turns its stream of received characters into framed BISYNC blocks. Each received byte is sorted into one of three kinds: fill, which is discarded; an escape prefix, which is consumed; or a delivered data character. Delivered characters leave on a registered output port with a per-byte event. A 16-bit block check sequence (BCS) is built over exactly the delivered characters. Software can inspect the first characters of a block through the per-byte event and then mask that event.

In normal mode every byte other than the SYNC value is delivered. Any delivered byte whose value is a valid entry of an eight-entry control table ends the block. Software enables transparent mode after it sees DLE followed by STX. In that mode a bare byte is always plain data, and a byte can close the block only when it comes directly after a DLE. The DLE prefix itself is stripped, a doubled DLE yields one data DLE, and DLE followed by SYNC is treated as fill.

A reset-BCS command pulse zeroes the accumulator. Software issues it after a header-opening character so that this character stays out of the check.

Top module: `bsc_rx_framer`

## Requirements
- R1: A byte that is delivered in the cycle where `rx_valid` is high appears on `out_byte`, with `out_valid` high for exactly one cycle, at the next clock edge. At most one byte is delivered per clock. After reset, `out_valid`, `byte_evt`, `block_end` and `bcs` are all zero.
- R2: With `xparent_en` low, a byte equal to the SYNC register is dropped and leaves the BCS unchanged. Every other byte is delivered. A DLE in this mode is ordinary data.
- R3: With `xparent_en` high, a DLE that does not follow a pending DLE is dropped and leaves the BCS unchanged. A DLE that follows a pending DLE is delivered as one data DLE and cannot end the block.
- R4: With `xparent_en` high, a byte that does not follow a DLE is delivered as data and never raises `block_end`. This includes the control-table values and the SYNC value.
- R5: With `xparent_en` high, a SYNC byte that follows a DLE is dropped, together with its prefix.
- R6: `block_end` is high together with `out_valid` when the delivered byte equals the value of a valid control-table entry. In normal mode any delivered byte can end the block in this way; in transparent mode only a DLE-prefixed byte can. Entries reset to invalid, and an invalid entry never matches. A table write sets the entry numbered `tbl_wr_idx` (0 to 7) to valid bit `tbl_wr_vld` and value `tbl_wr_char`.
- R7: `bcs` is a CRC-16 with reflected polynomial 0xA001 (x^16+x^15+x^2+1), initial value 0, processed LSB first. It is updated with every delivered byte, the ending character included, at the same edge as `out_valid`, and it is held otherwise. The ASCII string "123456789" gives 0xBB3D.
- R8: A `bcs_clear` pulse makes `bcs` zero at the next edge. A byte presented in the same cycle as the pulse is still delivered but is not accumulated.
- R9: `byte_evt` equals `out_valid` when `evt_mask` was low in the input cycle, and stays low when `evt_mask` was high.
- R10: A write with `chr_wr_en` high sets the SYNC register (`chr_wr_sel`=0) or the DLE register (`chr_wr_sel`=1) to `chr_wr_data`. The reset values are 0x32 and 0x10.
- R11: Dropping `xparent_en` cancels a pending DLE prefix, so the next byte is handled by normal-mode rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| xparent_en | input | 1 | Transparent mode enable |
| bcs_clear | input | 1 | Reset-BCS command pulse |
| evt_mask | input | 1 | Masks the per-byte event |
| chr_wr_en | input | 1 | SYNC/DLE register write strobe |
| chr_wr_sel | input | 1 | 0 selects SYNC, 1 selects DLE |
| chr_wr_data | input | 8 | SYNC/DLE write value |
| tbl_wr_en | input | 1 | Control table write strobe |
| tbl_wr_idx | input | 3 | Control table entry index |
| tbl_wr_vld | input | 1 | Valid bit written to the entry |
| tbl_wr_char | input | 8 | Character written to the entry |
| out_valid | output | 1 | Delivered byte strobe |
| out_byte | output | 8 | Delivered byte |
| byte_evt | output | 1 | Per-byte event (maskable) |
| block_end | output | 1 | End-of-block event |
| bcs | output | 16 | Running block check sequence |

## Verification
The assertions check several relations on every cycle. Any output strobe must trace back to an input strobe. `block_end` and `byte_evt` occur only together with a delivered byte. The BCS holds when nothing is delivered and reads zero after a clear. A bare SYNC in normal mode never produces output, and a pending escape does not survive leaving transparent mode. What cannot be seen from one cycle is left to the bench scenarios. These are the actual CRC values over escape and fill patterns, the "123456789" check value, the exclusion of the byte that arrives with a clear, and the effect of reprogrammed SYNC characters and table entries.

// File: rtl/bsc_rx_pkg.sv
package bsc_rx_pkg;
  localparam int DATA_W = 8;
  localparam int BCS_W  = 16;

  // One byte of LSB-first CRC with a reflected polynomial.
  function automatic logic [BCS_W-1:0] bcs_next(
    input logic [BCS_W-1:0]  cur,
    input logic [DATA_W-1:0] d,
    input logic [BCS_W-1:0]  poly_rev
  );
    logic [BCS_W-1:0] c;
    c = cur ^ {{(BCS_W-DATA_W){1'b0}}, d};
    for (int i = 0; i < DATA_W; i++) begin
      c = c[0] ? ((c >> 1) ^ poly_rev) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/bsc_ctl_table.sv
module bsc_ctl_table
  import bsc_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_char,
  input  logic [DATA_W-1:0] probe,
  output logic              hit
);
  logic [DEPTH-1:0]              ent_vld;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_chr;
  logic [DEPTH-1:0]              ent_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
        ent_chr[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_vld[g] <= wr_vld;
        ent_chr[g] <= wr_char;
      end
    end
    assign ent_hit[g] = ent_vld[g] && (ent_chr[g] == probe);
  end

  assign hit = |ent_hit;

  // R6: an invalid table never reports a hit
  assert_invalid_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld == '0) |-> !hit);
endmodule

// File: rtl/bsc_rx_classify.sv
module bsc_rx_classify
  import bsc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              xparent_en,
  input  logic [DATA_W-1:0] sync_chr,
  input  logic [DATA_W-1:0] dle_chr,
  output logic              deliver,
  output logic              ctl_ok
);
  logic esc_q, esc_d;
  logic is_dle, is_sync;

  assign is_dle  = (rx_byte == dle_chr);
  assign is_sync = (rx_byte == sync_chr);

  always_comb begin
    deliver = 1'b0;
    ctl_ok  = 1'b0;
    esc_d   = 1'b0;
    if (rx_valid) begin
      if (!xparent_en) begin
        deliver = !is_sync;
        ctl_ok  = 1'b1;
      end else if (!esc_q) begin
        esc_d   = is_dle;
        deliver = !is_dle;
      end else if (is_sync) begin
        deliver = 1'b0;
      end else begin
        deliver = 1'b1;
        ctl_ok  = !is_dle;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           esc_q <= 1'b0;
    else if (!xparent_en) esc_q <= 1'b0;
    else if (rx_valid)    esc_q <= esc_d;
  end

  // R11: leaving transparent mode cancels a pending prefix
  assert_esc_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !xparent_en |=> !esc_q);
  // R3: a fresh DLE in transparent mode is never delivered
  assert_dle_strip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xparent_en && rx_valid && !esc_q && is_dle) |-> !deliver);
  // R4: a bare byte in transparent mode never qualifies as control
  assert_bare_no_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xparent_en && !esc_q) |-> !ctl_ok);
endmodule

// File: rtl/bsc_bcs_accum.sv
module bsc_bcs_accum
  import bsc_rx_pkg::*;
#(
  parameter logic [BCS_W-1:0] POLY_REV = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic [DATA_W-1:0] data,
  output logic [BCS_W-1:0]  bcs
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) bcs <= '0;
    else if (upd)        bcs <= bcs_next(bcs, data, POLY_REV);
  end

  // R8: a clear leaves a zero accumulator
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bcs == '0));
  // R7: the accumulator holds when nothing is delivered
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !upd) |=> $stable(bcs));
endmodule

// File: rtl/bsc_rx_framer.sv
module bsc_rx_framer
  import bsc_rx_pkg::*;
#(
  parameter int                 TBL_DEPTH = 8,
  parameter logic [DATA_W-1:0]  SYNC_RST  = 8'h32,
  parameter logic [DATA_W-1:0]  DLE_RST   = 8'h10,
  parameter logic [BCS_W-1:0]   POLY_REV  = 16'hA001,
  localparam int TIDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              xparent_en,
  input  logic              bcs_clear,
  input  logic              evt_mask,
  input  logic              chr_wr_en,
  input  logic              chr_wr_sel,
  input  logic [DATA_W-1:0] chr_wr_data,
  input  logic              tbl_wr_en,
  input  logic [TIDX_W-1:0] tbl_wr_idx,
  input  logic              tbl_wr_vld,
  input  logic [DATA_W-1:0] tbl_wr_char,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              byte_evt,
  output logic              block_end,
  output logic [BCS_W-1:0]  bcs
);
  logic [DATA_W-1:0] sync_chr, dle_chr;
  logic              deliver, ctl_ok, tbl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_chr <= SYNC_RST;
      dle_chr  <= DLE_RST;
    end else if (chr_wr_en) begin
      if (chr_wr_sel) dle_chr  <= chr_wr_data;
      else            sync_chr <= chr_wr_data;
    end
  end

  bsc_rx_classify i_cls (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .xparent_en(xparent_en), .sync_chr(sync_chr), .dle_chr(dle_chr),
    .deliver(deliver), .ctl_ok(ctl_ok)
  );

  bsc_ctl_table #(.DEPTH(TBL_DEPTH)) i_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx),
    .wr_vld(tbl_wr_vld), .wr_char(tbl_wr_char), .probe(rx_byte), .hit(tbl_hit)
  );

  bsc_bcs_accum #(.POLY_REV(POLY_REV)) i_bcs (
    .clk(clk), .rst_n(rst_n), .clear(bcs_clear), .upd(deliver),
    .data(rx_byte), .bcs(bcs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      byte_evt  <= 1'b0;
      block_end <= 1'b0;
    end else begin
      out_valid <= deliver;
      byte_evt  <= deliver && !evt_mask;
      block_end <= deliver && ctl_ok && tbl_hit;
      if (deliver) out_byte <= rx_byte;
    end
  end

  // R1: every output strobe follows an input strobe
  assert_out_follows_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_valid));
  // R6: block end only on a delivered byte
  assert_end_with_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> out_valid);
  // R9: per-byte event only on a delivered byte
  assert_evt_with_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |-> out_valid);
  // R2: bare SYNC in normal mode yields nothing
  assert_sync_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !xparent_en && rx_byte == sync_chr) |=> !out_valid);
endmodule

// File: tb/test_bsc_rx_framer.sv
module test_bsc_rx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, xparent_en = 0, bcs_clear = 0, evt_mask = 0;
  logic [7:0] rx_byte = 0;
  logic chr_wr_en = 0, chr_wr_sel = 0;
  logic [7:0] chr_wr_data = 0;
  logic tbl_wr_en = 0, tbl_wr_vld = 0;
  logic [2:0] tbl_wr_idx = 0;
  logic [7:0] tbl_wr_char = 0;
  logic out_valid, byte_evt, block_end;
  logic [7:0] out_byte;
  logic [15:0] bcs;
  int n_chk = 0, n_bad = 0;
  logic [15:0] model_bcs = 0;

  always #2.5 clk = ~clk;

  bsc_rx_framer i_bsc_rx_framer (.*);

  typedef struct packed {
    logic       xp;
    logic [7:0] din;
    logic       v;
    logic [7:0] dout;
    logic       e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h32, 1'b0, 8'h00, 1'b0},  // R2 sync fill
    '{1'b0, 8'h32, 1'b0, 8'h00, 1'b0},  // R2
    '{1'b0, 8'h41, 1'b1, 8'h41, 1'b0},  // R6 invalid entry holds 'A'
    '{1'b0, 8'h10, 1'b1, 8'h10, 1'b0},  // R2 DLE is data in normal mode
    '{1'b0, 8'h03, 1'b1, 8'h03, 1'b1},  // R6 ETX ends block
    '{1'b1, 8'h03, 1'b1, 8'h03, 1'b0},  // R4 bare ETX is data
    '{1'b1, 8'h10, 1'b0, 8'h00, 1'b0},  // R3 prefix stripped
    '{1'b1, 8'h10, 1'b1, 8'h10, 1'b0},  // R3 DLE DLE gives DLE
    '{1'b1, 8'h32, 1'b1, 8'h32, 1'b0},  // R4 bare SYNC is data
    '{1'b1, 8'h10, 1'b0, 8'h00, 1'b0},  // R3
    '{1'b1, 8'h32, 1'b0, 8'h00, 1'b0},  // R5 DLE SYNC fill
    '{1'b1, 8'h10, 1'b0, 8'h00, 1'b0},  // R3
    '{1'b1, 8'h26, 1'b1, 8'h26, 1'b1}   // R6 DLE ETB ends block
  };

  // Bit-serial restatement of the CRC: one feedback bit per data bit.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ b[k];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one byte for one cycle; outputs are stable at the following negedge.
  task automatic send(input logic xp, input logic [7:0] b, input logic clr);
    @(negedge clk);
    xparent_en = xp; rx_byte = b; rx_valid = 1'b1; bcs_clear = clr;
    @(negedge clk);
    rx_valid = 1'b0; bcs_clear = 1'b0;
  endtask

  task automatic wr_tbl(input int idx, input logic vld, input logic [7:0] ch);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = idx[2:0]; tbl_wr_vld = vld; tbl_wr_char = ch;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rst out_valid", out_valid, 0);
    check("R1 rst block_end", block_end, 0);
    check("R1 rst byte_evt", byte_evt, 0);
    check("R1 rst bcs", bcs, 0);
    rst_n = 1'b1;

    // R6 table: ETX, ETB, ENQ valid; 'A' written invalid
    wr_tbl(0, 1, 8'h03);
    wr_tbl(1, 1, 8'h26);
    wr_tbl(2, 1, 8'h05);
    wr_tbl(3, 0, 8'h41);

    // vector walk: R1..R7
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].xp, VECS[i].din, 1'b0);
      if (VECS[i].v) model_bcs = ref_crc(model_bcs, VECS[i].din);
      check($sformatf("R1 vec%0d valid", i), out_valid, VECS[i].v);
      if (VECS[i].v) check($sformatf("R1 vec%0d byte", i), out_byte, VECS[i].dout);
      check($sformatf("R6 vec%0d end", i), block_end, VECS[i].e);
      check($sformatf("R9 vec%0d evt", i), byte_evt, VECS[i].v);
      check($sformatf("R7 vec%0d bcs", i), bcs, model_bcs);
    end
    @(negedge clk);
    check("R1 single-cycle strobe", out_valid, 0);

    // R8: SOH delivered with clear, not accumulated
    send(1'b0, 8'h01, 1'b1);
    check("R8 SOH delivered", out_valid, 1);
    check("R8 SOH excluded", bcs, 0);

    // R7 check value over "123456789" in transparent mode
    for (int i = 0; i < 9; i++) send(1'b1, 8'h31 + 8'(i), 1'b0);
    check("R7 check value", bcs, 16'hBB3D);

    // R9 masked event
    evt_mask = 1;
    send(1'b0, 8'h55, 1'b0);
    check("R9 masked evt", byte_evt, 0);
    check("R9 masked byte still out", out_valid, 1);
    evt_mask = 0;

    // R10 reprogram SYNC to 0x16
    @(negedge clk); chr_wr_en = 1; chr_wr_sel = 0; chr_wr_data = 8'h16;
    @(negedge clk); chr_wr_en = 0;
    send(1'b0, 8'h32, 1'b0);
    check("R10 old sync now data", out_valid, 1);
    send(1'b0, 8'h16, 1'b0);
    check("R10 new sync dropped", out_valid, 0);

    // R6 invalidate ETX entry
    wr_tbl(0, 0, 8'h03);
    send(1'b0, 8'h03, 1'b0);
    check("R6 invalidated entry", block_end, 0);

    // R11 pending prefix cancelled by leaving transparent mode
    send(1'b1, 8'h10, 1'b0);
    check("R11 prefix dropped", out_valid, 0);
    send(1'b0, 8'h26, 1'b0);
    check("R11 normal rules end", block_end, 1);
    send(1'b1, 8'h26, 1'b0);
    check("R11 no stale prefix", block_end, 0);

    summary();
  end
endmodule